// File: doc/BRIEF.md
# PHY Control Register File with Masked Writes

This block holds a small set of 32-bit control words and one read-only status word for an analog PHY. They sit behind a simple memory-mapped port: the write is single-cycle and the read is combinational. Each control word keeps 16 bits of state in its lower half.

The upper half of every write does not store data. Bit x+16 of the written word enables the update of bit x. Software can therefore set or clear single control bits without reading the word first.

One control word drives the PHY power enable and the DLL enable. Two PHY status inputs pass through a two-flop synchronizer and appear in the status word.

Top module: `phy_ctl_regfile`

## Requirements
- R1: After reset every control word reads 0, the status word reads 0 and both PHY control outputs are 0, so the PHY is powered down with its DLL disabled.
- R2: On a write to a control word, bit x (x from 0 to 15) takes bit x of the written data only when bit x+16 of the written data is 1. When that bit is 0, bit x keeps its previous value.
- R3: Bits 31 to 16 of every read return 0. The write mask is never stored.
- R4: Seven independent control words sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. A write to one of them leaves the others unchanged.
- R5: In the control word at offset 0x18, bit 0 drives `phy_pwr_on` (1 = powered) and bit 1 drives `phy_dll_en` (1 = DLL enabled).
- R6: The status word sits at offset 0x20. Bit 6 is calibration done, bit 5 is DLL ready, both active high, and all other bits read 0.
- R7: Writes to offset 0x20 have no effect on any state or output.
- R8: Offsets with bits [1:0] not zero, and aligned offsets other than the eight listed, read as 0. Writes to them are ignored.
- R9: A change on a status input becomes visible in the status word after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Byte offset of the access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write word: [31:16] bit-enable mask, [15:0] data |
| rd_data | output | 32 | Combinational read data for `addr` |
| phy_cal_done | input | 1 | Asynchronous calibration-done input from the PHY |
| phy_dll_ready | input | 1 | Asynchronous DLL-ready input from the PHY |
| phy_pwr_on | output | 1 | PHY power enable, bit 0 of offset 0x18 |
| phy_dll_en | output | 1 | PHY DLL enable, bit 1 of offset 0x18 |

## Verification
The bench covers several kinds of write:
- partial and empty masks, where a design that stored the mask, or ignored it, would read back a wrong lower half or nonzero upper bits;
- writes to the status offset and to unmapped or misaligned offsets, where a loose address decode would alias into a control word or change the PHY outputs;
- a mask that clears only the power bit, which must leave the DLL enable untouched.

It also measures the synchronizer latency edge by edge, so a missing or extra flop shows up one cycle early or late. Finally, a reset in the middle of the run must return everything to the powered-down state.

// File: rtl/phy_ctl_regfile.sv
module phy_ctl_regfile #(
  parameter int ADDR_W   = 6,
  parameter int NUM_CTRL = 7,
  parameter int STAT_OFS = 32,
  parameter int PWR_REG  = 6,
  parameter int CAL_BIT  = 6,
  parameter int DLL_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              phy_cal_done,
  input  logic              phy_dll_ready,
  output logic              phy_pwr_on,
  output logic              phy_dll_en
);
  localparam int HALF  = 16;
  localparam int IDX_W = $clog2(NUM_CTRL);

  logic [HALF-1:0]   ctrl_q [NUM_CTRL];
  logic [1:0]        cal_sync, dll_sync;
  logic [1:0]        since_rst;
  logic [ADDR_W-3:0] word_idx;
  logic              aligned, ctrl_hit, stat_hit;
  logic [HALF-1:0]   wmask, wdat;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign ctrl_hit = aligned && (int'(word_idx) < NUM_CTRL);
  assign stat_hit = (addr == STAT_OFS[ADDR_W-1:0]);
  assign wmask    = wr_data[31:HALF];
  assign wdat     = wr_data[HALF-1:0];

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_q[g] <= '0;
      else if (wr_en && ctrl_hit && int'(word_idx) == g)
        ctrl_q[g] <= (ctrl_q[g] & ~wmask) | (wdat & wmask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_sync  <= '0;
      dll_sync  <= '0;
      since_rst <= '0;
    end else begin
      cal_sync  <= {cal_sync[0], phy_cal_done};
      dll_sync  <= {dll_sync[0], phy_dll_ready};
      if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
  end

  always_comb begin
    rd_data = '0;
    if (ctrl_hit)
      rd_data[HALF-1:0] = ctrl_q[word_idx[IDX_W-1:0]];
    else if (stat_hit) begin
      rd_data[CAL_BIT] = cal_sync[1];
      rd_data[DLL_BIT] = dll_sync[1];
    end
  end

  assign phy_pwr_on = ctrl_q[PWR_REG][0];
  assign phy_dll_en = ctrl_q[PWR_REG][1];

  localparam logic [ADDR_W-1:0] PWR_ADDR = ADDR_W'(PWR_REG * 4);

  AST_RESET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!phy_pwr_on && !phy_dll_en)); // R1
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PWR_ADDR && !wr_data[16]) |=> $stable(phy_pwr_on)); // R2
  AST_PWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PWR_ADDR && wr_data[17]) |=> (phy_dll_en == $past(wr_data[1]))); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:HALF] == '0); // R3
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && stat_hit) |=> ($stable(phy_pwr_on) && $stable(phy_dll_en))); // R7
  AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (cal_sync[1] == $past(phy_cal_done, 2))); // R9
endmodule

// File: tb/phy_ctl_regfile_tb.sv
module phy_ctl_regfile_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  addr = '0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cal_in = 0, dll_in = 0;
  logic        pwr_on, dll_en;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phy_ctl_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .phy_cal_done(cal_in), .phy_dll_ready(dll_in),
    .phy_pwr_on(pwr_on), .phy_dll_en(dll_en));

  // {addr, write word, expected readback at the same addr}
  localparam logic [69:0] VEC [13] = '{
    {6'h00, 32'hFFFF_A5A5, 32'h0000_A5A5},  // R2 full mask
    {6'h00, 32'h00F0_FFFF, 32'h0000_A5F5},  // R2 partial mask
    {6'h00, 32'h0000_0000, 32'h0000_A5F5},  // R2 empty mask
    {6'h04, 32'hFFFF_1234, 32'h0000_1234},
    {6'h04, 32'h000F_0005, 32'h0000_1235},  // R2
    {6'h08, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R3
    {6'h08, 32'h0101_0000, 32'h0000_FEFE},  // R2 clear bits
    {6'h0C, 32'hFFFF_5A5A, 32'h0000_5A5A},
    {6'h10, 32'hFFFF_C3C3, 32'h0000_C3C3},
    {6'h14, 32'hFFFF_0F0F, 32'h0000_0F0F},
    {6'h18, 32'h0001_0001, 32'h0000_0001},  // R5
    {6'h18, 32'h0002_0002, 32'h0000_0003},  // R5
    {6'h00, 32'h0000_FFFF, 32'h0000_A5F5}   // R2
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) rd_chk("R1", 6'(i * 4), 32'h0);
    check("R1", {30'b0, dll_en, pwr_on}, 32'h0);

    for (int i = 0; i < 13; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd_chk("R2", VEC[i][69:64], VEC[i][31:0]);
    end

    rd_chk("R4", 6'h00, 32'h0000_A5F5);
    rd_chk("R4", 6'h04, 32'h0000_1235);
    rd_chk("R4", 6'h08, 32'h0000_FEFE);
    rd_chk("R4", 6'h0C, 32'h0000_5A5A);
    rd_chk("R4", 6'h10, 32'h0000_C3C3);
    rd_chk("R4", 6'h14, 32'h0000_0F0F);
    check("R5", {30'b0, dll_en, pwr_on}, 32'h3);

    wr(6'h18, 32'h0001_0000);
    check("R5", {30'b0, dll_en, pwr_on}, 32'h2);

    wr(6'h20, 32'hFFFF_FFFF);
    rd_chk("R7", 6'h20, 32'h0);
    check("R7", {30'b0, dll_en, pwr_on}, 32'h2);
    rd_chk("R7", 6'h18, 32'h0000_0002);

    wr(6'h1C, 32'hFFFF_FFFF);
    rd_chk("R8", 6'h1C, 32'h0);
    wr(6'h02, 32'hFFFF_FFFF);
    rd_chk("R8", 6'h02, 32'h0);
    rd_chk("R8", 6'h24, 32'h0);
    rd_chk("R8", 6'h3C, 32'h0);
    rd_chk("R8", 6'h00, 32'h0000_A5F5);
    check("R8", {30'b0, dll_en, pwr_on}, 32'h2);

    addr = 6'h20;
    @(negedge clk); cal_in = 1;
    @(posedge clk); #1 check("R9", rd_data, 32'h0);
    @(posedge clk); #1 check("R6", rd_data, 32'h40);
    @(negedge clk); dll_in = 1;
    @(posedge clk); #1 check("R9", rd_data, 32'h40);
    @(posedge clk); #1 check("R6", rd_data, 32'h60);
    @(negedge clk); cal_in = 0;
    @(posedge clk); #1 check("R9", rd_data, 32'h60);
    @(posedge clk); #1 check("R6", rd_data, 32'h20);

    @(negedge clk); rst_n = 0; dll_in = 0;
    #1;
    rd_chk("R1", 6'h00, 32'h0);
    rd_chk("R1", 6'h20, 32'h0);
    check("R1", {30'b0, dll_en, pwr_on}, 32'h0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd_chk("R1", 6'h14, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule